// File: doc/BRIEF.md
# Dual Overflow Count-Up Timer

This block holds a set of identical 32-bit up-counting timers behind one small memory-mapped register port. Each timer starts from a start value that software programs. It advances by one on every tick of its own prescaler. When it steps past its all-ones value it wraps to zero and raises a sticky overflow flag. Software clears that flag by writing a one to it. Each timer drives an interrupt line, which is its flag gated by an interrupt-enable bit.

A timer serves one of two uses. For a one-shot event, software loads the start register with the all-ones value minus the wanted delay, pulses the load bit and then sets the run bit. As a free-running time base, it starts from zero and software reads the live count. By default two timers sit side by side, one at offset 0x00 and one at offset 0x40. Bus address bits above the 64-byte stride select the timer.

Top module: `ovf_timer_pair`

## Requirements
- R1: After reset, every register of every timer reads 0 and every interrupt line is low.
- R2: Address bits [7:6] select the timer (timer 0 at 0x00, timer 1 at 0x40). Within a timer, the offsets are: flag 0x00, live count 0x04, control 0x10, setup 0x20, prescale 0x24, start value 0x28. Control and setup read back in bits [1:0], and any other offset reads 0. A write to one timer leaves the registers of the other timer unchanged.
- R3: While control bit 0 (load) is 1, the count holds the start value and does not advance.
- R4: The count advances only while setup bit 0 (enable) and control bit 1 (run) are 1 and load is 0. Otherwise it holds its value.
- R5: With prescale value D, the count advances once every D+1 clocks. The first advance comes D+1 clocks after run takes effect.
- R6: An advance from 0xFFFFFFFF wraps the count to 0 and sets flag bit 0, and the count keeps advancing. With start value 0xFFFFFFFF−N, the flag sets on the (N+1)th advance.
- R7: The interrupt line of a timer is high exactly when its flag is set and setup bit 1 (interrupt enable) is 1. The flag sets even when the interrupt is disabled.
- R8: A write to the flag register with bit 0 = 1 clears the flag, and a write with bit 0 = 0 leaves it unchanged. If a clearing write and a wrap land on the same clock, the flag stays set.
- R9: The live count register is read-only: a write to it leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_rd_en | input | 1 | Read strobe; read data is zero when low |
| bus_addr | input | 8 | Byte address (timer select and register offset) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| irq | output | 2 | One interrupt line per timer |

## Verification
On every cycle, the assertions check the counter's step rules: load forces the start value, the count holds without a tick and steps by exactly one with a tick, a wrap always sets the flag, the flag rises only on a wrap, and an interrupt never shows while the flag or the enable is clear. Some behaviours only the bench's scenarios can show, because they depend on register writes landing on particular clocks. These are the exact prescaler cadence, the one-shot delay arithmetic, the same-clock clear-versus-wrap collision, isolation between the two timers, and the address map.

// File: rtl/ovt_pkg.sv
package ovt_pkg;

   localparam logic [5:0] OFS_FLAG  = 6'h00;
   localparam logic [5:0] OFS_COUNT = 6'h04;
   localparam logic [5:0] OFS_CTRL  = 6'h10;
   localparam logic [5:0] OFS_SETUP = 6'h20;
   localparam logic [5:0] OFS_PSC   = 6'h24;
   localparam logic [5:0] OFS_START = 6'h28;

   // packed: last field is bit 0
   typedef struct packed {
      logic run;
      logic load;
   } ctrl_t;

   typedef struct packed {
      logic irq_en;
      logic enable;
   } setup_t;

endpackage

// File: rtl/ovt_prescaler.sv
module ovt_prescaler #(
   parameter int DIV_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   logic [DIV_W-1:0] phase_q;
   logic             at_end;

   assign at_end = (phase_q == div);
   assign tick   = run & at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
      end else if (!run || at_end) begin
         phase_q <= '0;
      end else begin
         phase_q <= phase_q + 1'b1;
      end
   end

endmodule

// File: rtl/ovt_counter.sv
module ovt_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] start_val,
   input  logic             step,
   output logic [CNT_W-1:0] count,
   output logic             wrap
);

   assign wrap = step & ~load & (&count);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (load) begin
         count <= start_val;
      end else if (step) begin
         count <= count + 1'b1;
      end
   end

endmodule

// File: rtl/ovt_unit.sv
module ovt_unit
   import ovt_pkg::*;
#(
   parameter int CNT_W   = 32,
   parameter int DIV_W   = 32,
   parameter int DATA_W  = 32,
   parameter int OFF_W   = 6,
   parameter bit USE_DIV = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [OFF_W-1:0]  off,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              irq,
   output logic [CNT_W-1:0]  cnt_o,
   output logic              flag_o,
   output logic              load_o,
   output logic              tick_o,
   output logic [CNT_W-1:0]  start_o,
   output logic              irq_en_o
);

   ctrl_t            ctrl_q;
   setup_t           setup_q;
   logic [CNT_W-1:0] start_q;
   logic [DIV_W-1:0] div_rd;
   logic             flag_q;
   logic             run;
   logic             tick;
   logic             wrap;
   logic [CNT_W-1:0] count;

   logic hit_flag, hit_count, hit_ctrl, hit_setup, hit_psc, hit_start;

   assign hit_flag  = (off == OFF_W'(OFS_FLAG));
   assign hit_count = (off == OFF_W'(OFS_COUNT));
   assign hit_ctrl  = (off == OFF_W'(OFS_CTRL));
   assign hit_setup = (off == OFF_W'(OFS_SETUP));
   assign hit_psc   = (off == OFF_W'(OFS_PSC));
   assign hit_start = (off == OFF_W'(OFS_START));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         setup_q <= '0;
         start_q <= '0;
      end else if (wr_en) begin
         if (hit_ctrl)  ctrl_q  <= ctrl_t'(wdata[1:0]);
         if (hit_setup) setup_q <= setup_t'(wdata[1:0]);
         if (hit_start) start_q <= wdata[CNT_W-1:0];
      end
   end

   // a wrap in the same clock beats a clearing write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (wrap) begin
         flag_q <= 1'b1;
      end else if (wr_en && hit_flag && wdata[0]) begin
         flag_q <= 1'b0;
      end
   end

   assign run = setup_q.enable & ctrl_q.run & ~ctrl_q.load;

   generate
      if (USE_DIV) begin : g_div
         logic [DIV_W-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               div_q <= '0;
            end else if (wr_en && hit_psc) begin
               div_q <= wdata[DIV_W-1:0];
            end
         end
         assign div_rd = div_q;
         ovt_prescaler #(.DIV_W(DIV_W)) u_psc (
            .clk  (clk),
            .rst_n(rst_n),
            .run  (run),
            .div  (div_q),
            .tick (tick)
         );
      end else begin : g_nodiv
         assign div_rd = '0;
         assign tick   = run;
      end
   endgenerate

   ovt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ctrl_q.load),
      .start_val(start_q),
      .step     (tick),
      .count    (count),
      .wrap     (wrap)
   );

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         if (hit_flag)  rdata = DATA_W'(flag_q);
         if (hit_count) rdata = DATA_W'(count);
         if (hit_ctrl)  rdata = DATA_W'(ctrl_q);
         if (hit_setup) rdata = DATA_W'(setup_q);
         if (hit_psc)   rdata = DATA_W'(div_rd);
         if (hit_start) rdata = DATA_W'(start_q);
      end
   end

   assign irq      = flag_q & setup_q.irq_en;
   assign cnt_o    = count;
   assign flag_o   = flag_q;
   assign load_o   = ctrl_q.load;
   assign tick_o   = tick;
   assign start_o  = start_q;
   assign irq_en_o = setup_q.irq_en;

endmodule

// File: rtl/ovf_timer_pair.sv
module ovf_timer_pair #(
   parameter int NUM_UNITS   = 2,
   parameter int CNT_W       = 32,
   parameter int DIV_W       = 32,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 8,
   parameter int STRIDE_LOG2 = 6,
   parameter bit USE_DIV     = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_wr_en,
   input  logic                 bus_rd_en,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   output logic [NUM_UNITS-1:0] irq
);

   localparam int SEL_W = ADDR_W - STRIDE_LOG2;

   generate
      if (CNT_W > DATA_W || DIV_W > DATA_W) begin : g_bad_width
         $error("counter and prescale widths must fit the data bus");
      end
      if (STRIDE_LOG2 < 6) begin : g_bad_stride
         $error("stride must cover the 0x28 register offset");
      end
      if (SEL_W < 1 || NUM_UNITS > (1 << SEL_W)) begin : g_bad_map
         $error("address width too small for the number of timers");
      end
   endgenerate

   logic [SEL_W-1:0]       unit_idx;
   logic [STRIDE_LOG2-1:0] unit_off;

   assign unit_idx = bus_addr[ADDR_W-1:STRIDE_LOG2];
   assign unit_off = bus_addr[STRIDE_LOG2-1:0];

   logic [NUM_UNITS-1:0][DATA_W-1:0] unit_rdata;
   logic [NUM_UNITS-1:0][CNT_W-1:0]  unit_cnt;
   logic [NUM_UNITS-1:0][CNT_W-1:0]  unit_start;
   logic [NUM_UNITS-1:0]             unit_flag;
   logic [NUM_UNITS-1:0]             unit_load;
   logic [NUM_UNITS-1:0]             unit_tick;
   logic [NUM_UNITS-1:0]             unit_irq_en;

   for (genvar gi = 0; gi < NUM_UNITS; gi++) begin : g_unit
      logic sel;
      assign sel = (unit_idx == SEL_W'(gi));

      ovt_unit #(
         .CNT_W  (CNT_W),
         .DIV_W  (DIV_W),
         .DATA_W (DATA_W),
         .OFF_W  (STRIDE_LOG2),
         .USE_DIV(USE_DIV)
      ) u_unit (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (bus_wr_en & sel),
         .rd_en   (bus_rd_en & sel),
         .off     (unit_off),
         .wdata   (bus_wdata),
         .rdata   (unit_rdata[gi]),
         .irq     (irq[gi]),
         .cnt_o   (unit_cnt[gi]),
         .flag_o  (unit_flag[gi]),
         .load_o  (unit_load[gi]),
         .tick_o  (unit_tick[gi]),
         .start_o (unit_start[gi]),
         .irq_en_o(unit_irq_en[gi])
      );
   end

   always_comb begin
      bus_rdata = '0;
      for (int k = 0; k < NUM_UNITS; k++) begin
         bus_rdata = bus_rdata | unit_rdata[k];
      end
   end

endmodule

// File: rtl/ovt_checker.sv
module ovt_checker #(
   parameter int NUM_UNITS = 2,
   parameter int CNT_W     = 32
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic [NUM_UNITS-1:0]            irq,
   input logic [NUM_UNITS-1:0][CNT_W-1:0] cnt,
   input logic [NUM_UNITS-1:0][CNT_W-1:0] start,
   input logic [NUM_UNITS-1:0]            flag,
   input logic [NUM_UNITS-1:0]            load,
   input logic [NUM_UNITS-1:0]            tick,
   input logic [NUM_UNITS-1:0]            irq_en
);

   for (genvar gi = 0; gi < NUM_UNITS; gi++) begin : g_chk
      a_r3_load_takes_start: assert property (@(posedge clk) disable iff (!rst_n)
         load[gi] |=> (cnt[gi] == $past(start[gi])));

      a_r4_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
         (!load[gi] && !tick[gi]) |=> $stable(cnt[gi]));

      a_r5_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
         (!load[gi] && tick[gi]) |=> (cnt[gi] == CNT_W'($past(cnt[gi]) + 1'b1)));

      a_r6_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
         (!load[gi] && tick[gi] && (&cnt[gi])) |=> (flag[gi] && cnt[gi] == '0));

      a_r8_flag_rises_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(flag[gi]) |-> ($past(tick[gi]) && (&$past(cnt[gi]))));

      a_r7_no_irq_without_flag: assert property (@(posedge clk) disable iff (!rst_n)
         !flag[gi] |-> !irq[gi]);

      a_r7_no_irq_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
         !irq_en[gi] |-> !irq[gi]);
   end

endmodule

bind ovf_timer_pair ovt_checker #(
   .NUM_UNITS(NUM_UNITS),
   .CNT_W    (CNT_W)
) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .irq   (irq),
   .cnt   (unit_cnt),
   .start (unit_start),
   .flag  (unit_flag),
   .load  (unit_load),
   .tick  (unit_tick),
   .irq_en(unit_irq_en)
);

// File: tb/ovf_timer_pair_tb.sv
`timescale 1ns/1ps
module ovf_timer_pair_tb;

   localparam logic [31:0] ALL1 = 32'hFFFF_FFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr_en = 1'b0;
   logic        bus_rd_en = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [1:0]  irq;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #2 clk = ~clk;

   ovf_timer_pair u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_wr_en(bus_wr_en),
      .bus_rd_en(bus_rd_en),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .irq      (irq)
   );

   // monitor: compares each read against the scoreboard head
   always @(negedge clk) begin
      if (bus_rd_en) begin
         logic [31:0] e;
         string t;
         n_checks++;
         if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL scoreboard: read with no expected item, actual %h", bus_rdata);
         end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (bus_rdata !== e) begin
               n_fail++;
               $display("FAIL %s: actual %h expected %h", t, bus_rdata, e);
            end
         end
      end
   end

   task automatic wr(input int unit, input logic [5:0] off, input logic [31:0] d);
      @(posedge clk); #1;
      bus_addr  = {unit[1:0], off};
      bus_wdata = d;
      bus_wr_en = 1'b1;
      @(posedge clk); #1;
      bus_wr_en = 1'b0;
   endtask

   task automatic rd(input int unit, input logic [5:0] off, input logic [31:0] e, input string t);
      @(posedge clk); #1;
      bus_addr = {unit[1:0], off};
      bus_rd_en = 1'b1;
      exp_q.push_back(e);
      tag_q.push_back(t);
      @(negedge clk); #1;
      bus_rd_en = 1'b0;
   endtask

   task automatic chk_irq(input logic [1:0] e, input string t);
      n_checks++;
      if (irq !== e) begin
         n_fail++;
         $display("FAIL %s: irq actual %b expected %b", t, irq, e);
      end
   endtask

   initial begin
      #200000;
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run did not finish");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state
      chk_irq(2'b00, "R1 irq after reset");
      for (int u = 0; u < 2; u++) begin
         rd(u, 6'h00, 32'h0, "R1 flag");
         rd(u, 6'h04, 32'h0, "R1 count");
         rd(u, 6'h10, 32'h0, "R1 control");
         rd(u, 6'h20, 32'h0, "R1 setup");
         rd(u, 6'h24, 32'h0, "R1 prescale");
         rd(u, 6'h28, 32'h0, "R1 start");
      end

      // R3 / R4: load, gating by enable and run
      wr(0, 6'h28, 32'd100);
      wr(0, 6'h10, 32'h1);
      rd(0, 6'h04, 32'd100, "R3 load start value");
      rd(0, 6'h10, 32'h1, "R2 control readback");
      wr(0, 6'h10, 32'h2);
      rd(0, 6'h04, 32'd100, "R4 no advance while disabled");
      wr(0, 6'h20, 32'h1);
      rd(0, 6'h04, 32'd101, "R4 first advance");
      rd(0, 6'h04, 32'd102, "R4 second advance");
      wr(0, 6'h10, 32'h0);
      rd(0, 6'h04, 32'd104, "R4 stop after run cleared");
      rd(0, 6'h04, 32'd104, "R4 held while stopped");

      // R5: prescale of 2 -> one advance per 3 clocks
      wr(0, 6'h28, 32'd1000);
      wr(0, 6'h10, 32'h1);
      wr(0, 6'h24, 32'd2);
      rd(0, 6'h24, 32'd2, "R2 prescale readback");
      wr(0, 6'h10, 32'h2);
      rd(0, 6'h04, 32'd1000, "R5 phase 1");
      rd(0, 6'h04, 32'd1000, "R5 phase 2");
      rd(0, 6'h04, 32'd1001, "R5 first divided advance");
      rd(0, 6'h04, 32'd1001, "R5 phase 4");
      rd(0, 6'h04, 32'd1001, "R5 phase 5");
      rd(0, 6'h04, 32'd1002, "R5 second divided advance");
      wr(0, 6'h10, 32'h1);
      wr(0, 6'h24, 32'd0);

      // R6: one-shot on timer 1, delay 5
      wr(1, 6'h28, ALL1 - 32'd5);
      wr(1, 6'h10, 32'h1);
      wr(1, 6'h20, 32'h3);
      rd(1, 6'h20, 32'h3, "R2 setup readback");
      wr(1, 6'h10, 32'h2);
      for (int k = 0; k < 5; k++) rd(1, 6'h00, 32'h0, "R6 flag before wrap");
      rd(1, 6'h00, 32'h1, "R6 flag on 6th advance");
      chk_irq(2'b10, "R7 timer 1 irq only");
      rd(1, 6'h04, 32'd1, "R6 keeps counting after wrap");
      wr(1, 6'h00, 32'h0);
      rd(1, 6'h00, 32'h1, "R8 zero write keeps flag");
      wr(1, 6'h00, 32'h1);
      rd(1, 6'h00, 32'h0, "R8 clear flag");
      chk_irq(2'b00, "R8 irq drops on clear");
      wr(1, 6'h10, 32'h0);

      // R7: flag sets with interrupt masked
      wr(0, 6'h28, ALL1 - 32'd1);
      wr(0, 6'h20, 32'h1);
      wr(0, 6'h10, 32'h2);
      rd(0, 6'h00, 32'h0, "R7 flag before wrap");
      rd(0, 6'h00, 32'h1, "R7 flag set while masked");
      chk_irq(2'b00, "R7 irq masked");
      wr(0, 6'h20, 32'h3);
      chk_irq(2'b01, "R7 irq after unmask");

      // R8: clear and wrap on the same clock
      wr(0, 6'h28, ALL1 - 32'd2);
      wr(0, 6'h10, 32'h1);
      wr(0, 6'h10, 32'h2);
      @(posedge clk);
      wr(0, 6'h00, 32'h1);
      rd(0, 6'h00, 32'h1, "R8 wrap wins over clear");
      wr(0, 6'h00, 32'h1);
      rd(0, 6'h00, 32'h0, "R8 clear after collision");

      // R9: count register ignores writes
      wr(0, 6'h10, 32'h1);
      wr(0, 6'h04, 32'h0000_1234);
      rd(0, 6'h04, ALL1 - 32'd2, "R9 count write ignored");

      // R2: map, isolation, unused offsets
      rd(1, 6'h28, ALL1 - 32'd5, "R2 timer 1 start untouched");
      rd(0, 6'h08, 32'h0, "R2 unused offset");
      wr(0, 6'h20, ALL1);
      rd(0, 6'h20, 32'h3, "R2 setup only two bits");
      rd(2, 6'h28, 32'h0, "R2 unmapped timer slot");

      repeat (2) @(posedge clk);
      n_checks++;
      if (exp_q.size() != 0) begin
         n_fail++;
         $display("FAIL scoreboard: %0d items left, expected 0", exp_q.size());
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule